// File: doc/BRIEF.md
# Indirect Configuration and IO Access Port

This block gives a host a narrow path into a PCI-style IO or configuration space through two registers inside a small register window. The host first loads a 32-bit target address into the pointer register, then reads or writes a four-byte data window. Each data-window access becomes one downstream request. The downstream address is the stored pointer with its two low bits replaced by the byte offset used inside the window.

Every access arriving on the upstream side carries an offset and a size code. The block checks whether that size is allowed at that offset. An illegal access gets an error response and produces no downstream activity. A legal data-window access is presented downstream with byte enables and big-endian lane placement. The request stays pending until the downstream side answers. Read data coming back is moved down to the low bits of the upstream response.

The pointer register is read back exactly as it was written. Its top bit is never treated as an enable: every legal data access is forwarded whatever that bit holds.

Top module: `cfgio_port`

## Requirements
- R1: After a synchronous reset, `up_ready` is 1, `dn_req_valid` and `up_rsp_valid` are 0, and the pointer register reads 0.
- R2: The pointer register sits at offsets 0-3 of the register window. A word-size access (size code 2) at offset 0 writes all 32 bits or reads them back unchanged, including bits [1:0] and bit 31. A write response carries read data 0.
- R3: Any pointer-register access that is not a word access at offset 0 gets an error response with read data 0. This covers offsets 1-3 and size codes 0 (byte), 1 (halfword) and 3 (reserved). The access leaves the pointer unchanged and issues no downstream request.
- R4: The data window sits at offsets 4-7, and the low two offset bits give the lane offset. At lane offset 0, byte, halfword and word are legal. At lane offset 2, byte and halfword are legal. At lane offsets 1 and 3, only byte is legal. Size code 3 is never legal. An illegal data access gets an error response and issues no downstream request.
- R5: A legal data access drives `dn_req_addr` = {pointer[31:2], lane offset}, whatever value pointer bit 31 holds.
- R6: `dn_req_be` is 4'b0001 shifted left by the lane offset for a byte, 4'b0011 shifted left by the lane offset for a halfword, and 4'b1111 for a word.
- R7: Lane k of `dn_req_wdata` (bits [8k+7:8k]) carries the byte at bus address base+k. The most significant byte of an n-byte upstream value goes to the lowest lane enabled. A byte access puts `up_wdata[7:0]` on its lane. Lanes that are not enabled are 0.
- R8: On a read, the enabled downstream lanes are placed in the low n bytes of `up_rsp_rdata`. The lowest enabled lane becomes the most significant of those n bytes. The remaining upper bits are 0.
- R9: From the cycle after acceptance, `dn_req_valid` stays high with address, byte enables, write flag and write data stable. It drops when `dn_rsp_valid` is sampled. `up_ready` stays low over the same span. A `dn_rsp_valid` pulse while no request is pending is ignored.
- R10: Every accepted access produces exactly one one-cycle `up_rsp_valid` pulse. The pulse comes in the cycle after acceptance for pointer accesses and errors, and in the cycle after `dn_rsp_valid` for forwarded accesses. `up_ready` returns high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream access request |
| up_ready | output | 1 | Block can accept an access |
| up_we | input | 1 | 1 = write, 0 = read |
| up_off | input | REG_AW | Byte offset in the register window |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| up_wdata | input | 32 | Write data, right-aligned |
| up_rsp_valid | output | 1 | Response pulse |
| up_rsp_err | output | 1 | Access was illegal |
| up_rsp_rdata | output | 32 | Read data, right-aligned |
| dn_req_valid | output | 1 | Downstream request pending |
| dn_req_we | output | 1 | Downstream write flag |
| dn_req_addr | output | 32 | Downstream byte address |
| dn_req_be | output | 4 | Downstream byte enables |
| dn_req_wdata | output | 32 | Downstream write data, lane-placed |
| dn_rsp_valid | input | 1 | Downstream completion |
| dn_rsp_rdata | input | 32 | Downstream read lanes |

## Verification
The hardest case to reach is a downstream request that has to hold steady across several idle cycles while stray upstream and downstream activity goes on around it. The stimulus creates this by delaying the downstream completion by a chosen number of cycles. During that delay the bench checks `up_ready`, `dn_req_valid` and the request fields every cycle. It also sends a `dn_rsp_valid` pulse while nothing is pending, and confirms that no response appears. Every size and offset pairing is driven in both directions against a behavioural model, which covers each legal and illegal case and each lane placement.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } state_e;
endpackage

// File: rtl/cfgio_legal_check.sv
module cfgio_legal_check
  import cfgio_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic [REG_AW-1:0] off,
  input  logic [1:0]        size,
  output logic              hit_window,
  output logic              hit_pointer,
  output logic              legal
);
  logic [1:0] lo;
  logic       win_ok;
  logic       ptr_ok;

  assign lo          = off[1:0];
  // bit 2 selects window vs pointer; any higher bit set is outside the space
  assign hit_window  = ((off >> 3) == '0) && off[2];
  assign hit_pointer = ((off >> 3) == '0) && !off[2];

  always_comb begin
    win_ok = 1'b0;
    unique case (lo)
      2'd0:       win_ok = (size != SZ_RSVD);
      2'd2:       win_ok = (size == SZ_BYTE) || (size == SZ_HALF);
      default:    win_ok = (size == SZ_BYTE);
    endcase
  end

  assign ptr_ok = (lo == 2'd0) && (size == SZ_WORD);
  assign legal  = hit_window ? win_ok : (hit_pointer ? ptr_ok : 1'b0);
endmodule

// File: rtl/cfgio_wr_map.sv
module cfgio_wr_map #(
  parameter int DW = 32
) (
  input  logic [1:0]    lo,
  input  logic [1:0]    size,
  input  logic [DW-1:0] up_data,
  output logic [DW/8-1:0] be,
  output logic [DW-1:0] dn_data
);
  localparam int LANES = DW / 8;

  always_comb begin : p_place
    int n;
    int j;
    n       = 1 << size;
    be      = '0;
    dn_data = '0;
    for (int k = 0; k < LANES; k++) begin
      j = k - int'(lo);
      if (j >= 0 && j < n && (n - 1 - j) < LANES) begin
        be[k]              = 1'b1;
        dn_data[8*k +: 8]  = up_data[8*(n-1-j) +: 8];
      end
    end
  end
endmodule

// File: rtl/cfgio_rd_map.sv
module cfgio_rd_map #(
  parameter int DW = 32
) (
  input  logic [1:0]    lo,
  input  logic [1:0]    size,
  input  logic [DW-1:0] dn_data,
  output logic [DW-1:0] up_data
);
  localparam int LANES = DW / 8;

  always_comb begin : p_gather
    int n;
    int src;
    n       = 1 << size;
    up_data = '0;
    for (int i = 0; i < LANES; i++) begin
      src = int'(lo) + n - 1 - i;
      if (i < n && src >= 0 && src < LANES) begin
        up_data[8*i +: 8] = dn_data[8*src +: 8];
      end
    end
  end
endmodule

// File: rtl/cfgio_port.sv
module cfgio_port
  import cfgio_pkg::*;
#(
  parameter int REG_AW = 3,
  parameter int ADDR_W = 32,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_we,
  input  logic [REG_AW-1:0] up_off,
  input  logic [1:0]        up_size,
  input  logic [DW-1:0]     up_wdata,
  output logic              up_rsp_valid,
  output logic              up_rsp_err,
  output logic [DW-1:0]     up_rsp_rdata,
  output logic              dn_req_valid,
  output logic              dn_req_we,
  output logic [ADDR_W-1:0] dn_req_addr,
  output logic [DW/8-1:0]   dn_req_be,
  output logic [DW-1:0]     dn_req_wdata,
  input  logic              dn_rsp_valid,
  input  logic [DW-1:0]     dn_rsp_rdata
);
  localparam int LANES = DW / 8;
  localparam int LOW_W = $clog2(LANES);

  state_e            st;
  logic [ADDR_W-1:0] ptr_q;
  logic [1:0]        cap_lo;
  logic [1:0]        cap_size;

  logic              hit_win;
  logic              hit_ptr;
  logic              legal;
  logic [LANES-1:0]  map_be;
  logic [DW-1:0]     map_wdata;
  logic [DW-1:0]     map_rdata;
  logic              accept;

  cfgio_legal_check #(.REG_AW(REG_AW)) u_legal (
    .off         (up_off),
    .size        (up_size),
    .hit_window  (hit_win),
    .hit_pointer (hit_ptr),
    .legal       (legal)
  );

  cfgio_wr_map #(.DW(DW)) u_wr_map (
    .lo      (up_off[1:0]),
    .size    (up_size),
    .up_data (up_wdata),
    .be      (map_be),
    .dn_data (map_wdata)
  );

  cfgio_rd_map #(.DW(DW)) u_rd_map (
    .lo      (cap_lo),
    .size    (cap_size),
    .dn_data (dn_rsp_rdata),
    .up_data (map_rdata)
  );

  assign up_ready = (st == ST_IDLE);
  assign accept   = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      ptr_q        <= '0;
      cap_lo       <= '0;
      cap_size     <= '0;
      up_rsp_valid <= 1'b0;
      up_rsp_err   <= 1'b0;
      up_rsp_rdata <= '0;
      dn_req_valid <= 1'b0;
      dn_req_we    <= 1'b0;
      dn_req_addr  <= '0;
      dn_req_be    <= '0;
      dn_req_wdata <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          up_rsp_valid <= 1'b0;
          if (accept) begin
            if (!legal) begin
              up_rsp_valid <= 1'b1;
              up_rsp_err   <= 1'b1;
              up_rsp_rdata <= '0;
              st           <= ST_RESP;
            end else if (hit_win) begin
              dn_req_valid <= 1'b1;
              dn_req_we    <= up_we;
              dn_req_addr  <= {ptr_q[ADDR_W-1:LOW_W], up_off[LOW_W-1:0]};
              dn_req_be    <= map_be;
              dn_req_wdata <= map_wdata;
              cap_lo       <= up_off[1:0];
              cap_size     <= up_size;
              st           <= ST_WAIT;
            end else begin
              if (up_we) begin
                ptr_q <= up_wdata[ADDR_W-1:0];
              end
              up_rsp_valid <= 1'b1;
              up_rsp_err   <= 1'b0;
              up_rsp_rdata <= up_we ? '0 : DW'(ptr_q);
              st           <= ST_RESP;
            end
          end
        end
        ST_WAIT: begin
          if (dn_rsp_valid) begin
            dn_req_valid <= 1'b0;
            up_rsp_valid <= 1'b1;
            up_rsp_err   <= 1'b0;
            up_rsp_rdata <= dn_req_we ? '0 : map_rdata;
            st           <= ST_RESP;
          end
        end
        default: begin
          up_rsp_valid <= 1'b0;
          st           <= ST_IDLE;
        end
      endcase
    end
  end

  // hit_ptr is implied by legal && !hit_win; kept visible for the checks below
  a_r3_ptr_err_quiet: assert property (@(posedge clk) disable iff (rst)
    accept && hit_ptr && !legal |=> up_rsp_err && !dn_req_valid);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid && !dn_rsp_valid |=> dn_req_valid && $stable(dn_req_addr)
      && $stable(dn_req_be) && $stable(dn_req_wdata) && $stable(dn_req_we));

  a_r9_busy_while_pending: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid |-> !up_ready);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    up_rsp_valid |=> !up_rsp_valid && up_ready);

  a_r6_be_shape: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid |-> ($countones(dn_req_be) == 1 || $countones(dn_req_be) == 2
      || $countones(dn_req_be) == LANES));

  a_r4_half_aligned: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid && $countones(dn_req_be) == 2 |-> !dn_req_addr[0]);

  a_r3_err_no_req: assert property (@(posedge clk) disable iff (rst)
    up_rsp_valid && up_rsp_err |-> !dn_req_valid);
endmodule

// File: tb/cfgio_port_tb.sv
`timescale 1ns/1ps
module cfgio_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        up_valid = 1'b0;
  logic        up_ready;
  logic        up_we = 1'b0;
  logic [2:0]  up_off = '0;
  logic [1:0]  up_size = '0;
  logic [31:0] up_wdata = '0;
  logic        up_rsp_valid;
  logic        up_rsp_err;
  logic [31:0] up_rsp_rdata;
  logic        dn_req_valid;
  logic        dn_req_we;
  logic [31:0] dn_req_addr;
  logic [3:0]  dn_req_be;
  logic [31:0] dn_req_wdata;
  logic        dn_rsp_valid = 1'b0;
  logic [31:0] dn_rsp_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] m_ptr = '0;

  always #2 clk = ~clk;

  cfgio_port u_dut (
    .clk(clk), .rst(rst),
    .up_valid(up_valid), .up_ready(up_ready), .up_we(up_we),
    .up_off(up_off), .up_size(up_size), .up_wdata(up_wdata),
    .up_rsp_valid(up_rsp_valid), .up_rsp_err(up_rsp_err), .up_rsp_rdata(up_rsp_rdata),
    .dn_req_valid(dn_req_valid), .dn_req_we(dn_req_we), .dn_req_addr(dn_req_addr),
    .dn_req_be(dn_req_be), .dn_req_wdata(dn_req_wdata),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_rdata(dn_rsp_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock; compare the handshake outputs at the falling edge
  task automatic tick(input logic e_rdy, input logic e_dn, input logic e_rsp);
    @(negedge clk);
    chk("R9 up_ready", {31'd0, up_ready}, {31'd0, e_rdy});
    chk("R9 dn_req_valid", {31'd0, dn_req_valid}, {31'd0, e_dn});
    chk("R10 up_rsp_valid", {31'd0, up_rsp_valid}, {31'd0, e_rsp});
  endtask

  function automatic bit m_legal(input int off, input int sz);
    int lo = off % 4;
    if (sz == 3 || off > 7) return 0;
    if (off < 4) return (lo == 0 && sz == 2);
    if (lo == 0) return 1;
    if (lo == 2) return (sz <= 1);
    return (sz == 0);
  endfunction

  function automatic logic [3:0] m_be(input int lo, input int sz);
    logic [3:0] b = '0;
    for (int a = lo; a < lo + (1 << sz); a++) b[a] = 1'b1;
    return b;
  endfunction

  function automatic logic [31:0] m_lanes(input int lo, input int sz, input logic [31:0] v);
    logic [31:0] r = '0;
    int n = 1 << sz;
    for (int b = 0; b < n; b++) r[8*(lo+b) +: 8] = v[8*(n-1-b) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] m_unlane(input int lo, input int sz, input logic [31:0] v);
    logic [31:0] r = '0;
    int n = 1 << sz;
    for (int b = 0; b < n; b++) r[8*(n-1-b) +: 8] = v[8*(lo+b) +: 8];
    return r;
  endfunction

  task automatic access(input bit we, input int off, input int sz,
                        input logic [31:0] wd, input int lat, input logic [31:0] dd,
                        input string tag);
    bit ok = m_legal(off, sz);
    bit fwd = ok && off >= 4;
    int lo = off % 4;
    logic [31:0] a0;
    up_valid = 1'b1; up_we = we; up_off = off[2:0]; up_size = sz[1:0]; up_wdata = wd;
    tick(1'b0, fwd, !fwd);
    up_valid = 1'b0;
    if (fwd) begin
      a0 = {m_ptr[31:2], lo[1:0]};
      chk({tag, " R5 addr"}, dn_req_addr, a0);
      chk({tag, " R6 be"}, {28'd0, dn_req_be}, {28'd0, m_be(lo, sz)});
      chk({tag, " R7 we"}, {31'd0, dn_req_we}, {31'd0, we});
      if (we) chk({tag, " R7 wdata"}, dn_req_wdata, m_lanes(lo, sz, wd));
      for (int c = 0; c < lat; c++) begin
        tick(1'b0, 1'b1, 1'b0);
        chk({tag, " R9 addr hold"}, dn_req_addr, a0);
      end
      dn_rsp_valid = 1'b1; dn_rsp_rdata = dd;
      tick(1'b0, 1'b0, 1'b1);
      dn_rsp_valid = 1'b0; dn_rsp_rdata = '0;
      chk({tag, " R10 err"}, {31'd0, up_rsp_err}, 32'd0);
      chk({tag, " R8 rdata"}, up_rsp_rdata, we ? 32'd0 : m_unlane(lo, sz, dd));
    end else begin
      chk({tag, " R3/R4 err"}, {31'd0, up_rsp_err}, {31'd0, !ok});
      if (ok) begin
        chk({tag, " R2 rdata"}, up_rsp_rdata, we ? 32'd0 : m_ptr);
        if (we) m_ptr = wd;
      end else begin
        chk({tag, " R3 rdata"}, up_rsp_rdata, 32'd0);
      end
    end
    tick(1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 up_ready", {31'd0, up_ready}, 32'd1);
    chk("R1 dn_req_valid", {31'd0, dn_req_valid}, 32'd0);
    chk("R1 up_rsp_valid", {31'd0, up_rsp_valid}, 32'd0);
    access(0, 0, 2, 0, 0, 0, "R1 ptr read");
    // R2 full-width pointer incl. bit31 and low bits
    access(1, 0, 2, 32'h8000_1237, 0, 0, "R2 ptr write");
    access(0, 0, 2, 0, 0, 0, "R2 ptr readback");
    // R3 bad pointer accesses leave pointer unchanged
    access(1, 0, 1, 32'hFFFF_FFFF, 0, 0, "R3 half");
    access(1, 0, 0, 32'hFFFF_FFFF, 0, 0, "R3 byte");
    access(1, 0, 3, 32'hFFFF_FFFF, 0, 0, "R3 rsvd");
    access(1, 1, 2, 32'hFFFF_FFFF, 0, 0, "R3 off1");
    access(0, 3, 0, 0, 0, 0, "R3 off3");
    access(0, 0, 2, 0, 0, 0, "R3 unchanged");
    // R9 stray completion while idle is ignored
    dn_rsp_valid = 1'b1; dn_rsp_rdata = 32'hDEAD_BEEF;
    tick(1'b1, 1'b0, 1'b0);
    dn_rsp_valid = 1'b0;
    tick(1'b1, 1'b0, 1'b0);
    // R4..R8 every offset and size in the window, both directions
    for (int off = 4; off < 8; off++) begin
      for (int sz = 0; sz < 4; sz++) begin
        access(1, off, sz, 32'h1122_3344 + off, (off + sz) % 3, 0, "R4/R7 wr");
        access(0, off, sz, 0, sz, 32'hA1B2_C3D4 ^ off, "R4/R8 rd");
      end
    end
    // R5 low pointer bits never reach the bus
    access(1, 0, 2, 32'h0000_0003, 0, 0, "R5 ptr");
    access(0, 6, 1, 0, 4, 32'hCAFE_F00D, "R5 rd");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule